// File: doc/BRIEF.md
# Operand Addressing-Mode Resolver

This block takes one six-bit operand code and resolves it into the word the operand reads and the place a result would be written back to. The code can name a general register, a memory word addressed through a register, a memory word at a next-word offset plus a register, the top of a descending stack (pop, peek or push), the stack pointer, the program counter, the overflow register, a memory word at an absolute next-word address, a next-word literal or a short literal built into the code. The caller supplies the register file, SP, PC and the overflow word, and gets back the value, a write-target descriptor, the updated SP and PC, and the operand's architectural cycle cost.

Operands that need a word from memory use a synchronous read port: one request cycle, with the data returned on the following cycle. A next-word fetch reads at PC and advances PC by one. The caller resolves a two-operand instruction by running the first operand, then starting the second with the SP and PC that the first one returned. Opcode execution is outside this block.

Top module: `opr_resolver`

## Requirements
- R1: Codes 0x00..0x07 select register n = code (slice regs_i[16n+15:16n], order A, B, C, X, Y, Z, I, J). value_o is that register, dst_kind_o is 1, dst_sel_o is n, and done_o rises one cycle after the start edge with no memory request.
- R2: Codes 0x08..0x0f read memory at the address held in register code-8. value_o is that word, dst_kind_o is 2, dst_addr_o is that address, and done_o rises three cycles after the start edge.
- R3: Codes 0x10..0x17 first read the next word at PC and then read memory at (next word + register code-16) mod 2^16. dst_kind_o is 2 with that address, pc_o is PC+1, and done_o rises five cycles after the start edge.
- R4: Code 0x18 reads memory at SP and returns sp_o = SP+1 (mod 2^16); code 0x19 reads memory at SP and returns sp_o = SP. Both report dst_kind_o 2 with dst_addr_o = SP.
- R5: Code 0x1a returns sp_o = SP-1 (mod 2^16, so SP 0x0000 gives 0xffff), and the read and dst_addr_o both use that new SP.
- R6: Codes 0x1b, 0x1c and 0x1d return value_o equal to SP, PC and the overflow word, with dst_kind_o 3, 4 and 5 respectively, without a memory request, done one cycle after start.
- R7: Code 0x1e reads the next word and then memory at that address (dst_kind_o 2). Code 0x1f returns the next word itself. Codes 0x20..0x3f return value_o = code-0x20 with no memory request.
- R8: Codes 0x1f and 0x20..0x3f report dst_kind_o 0 (no write target). dst_addr_o is 0 whenever dst_kind_o is not 2.
- R9: cycles_o is 1 for codes 0x10..0x17, 0x1e and 0x1f and 0 otherwise. pc_o is PC+1 (mod 2^16) for exactly those codes and PC for all others.
- R10: mem_req_o is high for single cycles only, and the word on mem_rdata_i is taken on the cycle after each request. A resolution issues zero, one or two requests: the next-word fetch at PC comes first.
- R11: done_o is a one-cycle pulse that marks value_o, dst_*_o, sp_o, pc_o and cycles_o valid. A start_i asserted while a resolution is in flight, including its done cycle, is ignored.
- R12: While rst_ni is low, done_o and mem_req_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving code_i (taken only when idle) |
| code_i | input | 6 | Operand code |
| regs_i | input | 128 | Eight 16-bit general registers, register n at bits 16n+15:16n |
| sp_i | input | 16 | Current stack pointer |
| pc_i | input | 16 | Current program counter |
| o_i | input | 16 | Current overflow word |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a request |
| done_o | output | 1 | Result valid pulse |
| value_o | output | 16 | Operand value |
| dst_kind_o | output | 3 | Write target: 0 none, 1 register, 2 memory, 3 SP, 4 PC, 5 overflow |
| dst_sel_o | output | 3 | Register index when dst_kind_o is 1 |
| dst_addr_o | output | 16 | Memory address when dst_kind_o is 2, else 0 |
| sp_o | output | 16 | Stack pointer after side effects |
| pc_o | output | 16 | Program counter after next-word fetches |
| cycles_o | output | 2 | Architectural cycle cost of the operand |

## Verification
A wrong latched mode or register selection shows at the very next done pulse as a wrong value, kind or address, and a wrong state sequence shows earlier, as a request on a cycle where none was due or a done pulse one or more cycles off its fixed latency of one, three or five cycles. Because the reference model predicts the request line, its address and the done line for every cycle of every resolution, a fault in the sequencing is seen on the first cycle it diverges, not only at the result. Stack and PC side effects are compared at each done pulse, including the wrap at both ends of the address space.

// File: rtl/opr_pkg.sv
package opr_pkg;
  parameter int unsigned DW    = 16;
  parameter int unsigned NREG  = 8;
  parameter int unsigned CW    = 6;
  parameter int unsigned CYC_W = 2;
  localparam int unsigned RSW  = $clog2(NREG);
  localparam int unsigned KW   = 3;

  typedef enum logic [KW-1:0] {
    DST_NONE = 3'd0,
    DST_REG  = 3'd1,
    DST_MEM  = 3'd2,
    DST_SP   = 3'd3,
    DST_PC   = 3'd4,
    DST_O    = 3'd5
  } dst_e;

  typedef enum logic [3:0] {
    M_REG, M_IND, M_IDX, M_POP, M_PEEK, M_PUSH,
    M_SP, M_PC, M_O, M_ABS, M_NWLIT, M_SLIT
  } mode_e;

  typedef struct packed {
    mode_e          mode;
    logic [RSW-1:0] sel;
    logic           need_nw;
    logic           need_mem;
  } dec_t;

  function automatic dst_e dst_of(mode_e m);
    case (m)
      M_REG:                                    return DST_REG;
      M_IND, M_IDX, M_POP, M_PEEK, M_PUSH, M_ABS: return DST_MEM;
      M_SP:                                     return DST_SP;
      M_PC:                                     return DST_PC;
      M_O:                                      return DST_O;
      default:                                  return DST_NONE;
    endcase
  endfunction
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [CW-1:0] code_i,
  output dec_t          dec_o
);
  always_comb begin
    dec_o.sel  = code_i[RSW-1:0];
    dec_o.mode = M_SLIT;
    case (code_i[CW-1:RSW])
      3'd0: dec_o.mode = M_REG;
      3'd1: dec_o.mode = M_IND;
      3'd2: dec_o.mode = M_IDX;
      3'd3: begin
        case (code_i[RSW-1:0])
          3'd0:    dec_o.mode = M_POP;
          3'd1:    dec_o.mode = M_PEEK;
          3'd2:    dec_o.mode = M_PUSH;
          3'd3:    dec_o.mode = M_SP;
          3'd4:    dec_o.mode = M_PC;
          3'd5:    dec_o.mode = M_O;
          3'd6:    dec_o.mode = M_ABS;
          default: dec_o.mode = M_NWLIT;
        endcase
      end
      default: dec_o.mode = M_SLIT;
    endcase
    dec_o.need_nw  = dec_o.mode inside {M_IDX, M_ABS, M_NWLIT};
    dec_o.need_mem = dec_o.mode inside {M_IND, M_IDX, M_POP, M_PEEK, M_PUSH, M_ABS};
  end
endmodule

// File: rtl/opr_stack.sv
module opr_stack
  import opr_pkg::*;
(
  input  mode_e         mode_i,
  input  logic [DW-1:0] sp_i,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] addr_o
);
  // descending stack: push pre-decrements, pop post-increments
  always_comb begin
    sp_o   = sp_i;
    addr_o = sp_i;
    case (mode_i)
      M_POP:  sp_o = sp_i + DW'(1);
      M_PUSH: begin
        sp_o   = sp_i - DW'(1);
        addr_o = sp_i - DW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opr_addr.sv
module opr_addr
  import opr_pkg::*;
(
  input  mode_e         mode_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] nw_i,
  input  logic [DW-1:0] stk_i,
  output logic [DW-1:0] addr_o
);
  always_comb begin
    case (mode_i)
      M_IND:                addr_o = reg_i;
      M_IDX:                addr_o = nw_i + reg_i;
      M_ABS:                addr_o = nw_i;
      M_POP, M_PEEK, M_PUSH: addr_o = stk_i;
      default:              addr_o = '0;
    endcase
  end
endmodule

// File: rtl/opr_resolver.sv
module opr_resolver
  import opr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CW-1:0]       code_i,
  input  logic [NREG*DW-1:0]  regs_i,
  input  logic [DW-1:0]       sp_i,
  input  logic [DW-1:0]       pc_i,
  input  logic [DW-1:0]       o_i,
  output logic                mem_req_o,
  output logic [DW-1:0]       mem_addr_o,
  input  logic [DW-1:0]       mem_rdata_i,
  output logic                done_o,
  output logic [DW-1:0]       value_o,
  output logic [KW-1:0]       dst_kind_o,
  output logic [RSW-1:0]      dst_sel_o,
  output logic [DW-1:0]       dst_addr_o,
  output logic [DW-1:0]       sp_o,
  output logic [DW-1:0]       pc_o,
  output logic [CYC_W-1:0]    cycles_o
);
  typedef enum logic [2:0] {S_IDLE, S_NW, S_NW_RD, S_MEM, S_MEM_RD, S_DONE} st_e;

  st_e           st_q;
  dec_t          dec, dec_q;
  logic [DW-1:0] reg_arr [NREG];
  logic [DW-1:0] regv_q, sp_q, pc_q, val_q, addr_q;
  logic [DW-1:0] sp_new, stk_addr, addr_calc, reg_src;
  mode_e         mode_src;
  logic          take;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign reg_arr[g] = regs_i[g*DW +: DW];
  end

  opr_decode u_dec (
    .code_i (code_i),
    .dec_o  (dec)
  );

  opr_stack u_stk (
    .mode_i (dec.mode),
    .sp_i   (sp_i),
    .sp_o   (sp_new),
    .addr_o (stk_addr)
  );

  // idle: live decode; after next-word fetch: latched mode and register
  assign mode_src = (st_q == S_IDLE) ? dec.mode : dec_q.mode;
  assign reg_src  = (st_q == S_IDLE) ? reg_arr[dec.sel] : regv_q;

  opr_addr u_addr (
    .mode_i (mode_src),
    .reg_i  (reg_src),
    .nw_i   (mem_rdata_i),
    .stk_i  (stk_addr),
    .addr_o (addr_calc)
  );

  assign take = (st_q == S_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      dec_q  <= '0;
      regv_q <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
      val_q  <= '0;
      addr_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (take) begin
          dec_q  <= dec;
          regv_q <= reg_arr[dec.sel];
          sp_q   <= sp_new;
          pc_q   <= pc_i;
          addr_q <= addr_calc;
          case (dec.mode)
            M_REG:   val_q <= reg_arr[dec.sel];
            M_SP:    val_q <= sp_i;
            M_PC:    val_q <= pc_i;
            M_O:     val_q <= o_i;
            M_SLIT:  val_q <= {{(DW-5){1'b0}}, code_i[4:0]};
            default: val_q <= '0;
          endcase
          if (dec.need_nw)       st_q <= S_NW;
          else if (dec.need_mem) st_q <= S_MEM;
          else                   st_q <= S_DONE;
        end
        S_NW: begin
          pc_q <= pc_q + DW'(1);
          st_q <= S_NW_RD;
        end
        S_NW_RD: begin
          addr_q <= addr_calc;
          if (dec_q.need_mem) st_q <= S_MEM;
          else begin
            val_q <= mem_rdata_i;
            st_q  <= S_DONE;
          end
        end
        S_MEM:    st_q <= S_MEM_RD;
        S_MEM_RD: begin
          val_q <= mem_rdata_i;
          st_q  <= S_DONE;
        end
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == S_NW) || (st_q == S_MEM);
  assign mem_addr_o = (st_q == S_NW) ? pc_q : addr_q;
  assign done_o     = (st_q == S_DONE);
  assign value_o    = val_q;
  assign dst_kind_o = dst_of(dec_q.mode);
  assign dst_sel_o  = dec_q.sel;
  assign dst_addr_o = addr_q;
  assign sp_o       = sp_q;
  assign pc_o       = pc_q;
  assign cycles_o   = CYC_W'(dec_q.need_nw);
endmodule

// File: rtl/opr_resolver_chk.sv
module opr_resolver_chk
  import opr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CW-1:0]    code_i,
  input logic [DW-1:0]    sp_i,
  input logic [DW-1:0]    pc_i,
  input logic             mem_req_o,
  input logic             done_o,
  input logic [KW-1:0]    dst_kind_o,
  input logic [DW-1:0]    dst_addr_o,
  input logic [DW-1:0]    sp_o,
  input logic [DW-1:0]    pc_o,
  input logic [CYC_W-1:0] cycles_o
);
  logic          pend;
  logic [CW-1:0] code_c;
  logic [DW-1:0] sp_c, pc_c;
  logic [2:0]    req_cnt;
  logic          nw_c, mem_c, lit_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend    <= 1'b0;
      code_c  <= '0;
      sp_c    <= '0;
      pc_c    <= '0;
      req_cnt <= '0;
    end else if (!pend && start_i) begin
      pend    <= 1'b1;
      code_c  <= code_i;
      sp_c    <= sp_i;
      pc_c    <= pc_i;
      req_cnt <= '0;
    end else begin
      if (done_o)    pend    <= 1'b0;
      if (mem_req_o) req_cnt <= req_cnt + 3'd1;
    end
  end

  assign nw_c  = (code_c[5:3] == 3'd2) || (code_c == 6'h1e) || (code_c == 6'h1f);
  assign mem_c = (code_c[5:3] == 3'd1) || (code_c[5:3] == 3'd2) ||
                 (code_c == 6'h18) || (code_c == 6'h19) || (code_c == 6'h1a) ||
                 (code_c == 6'h1e);
  assign lit_c = code_c[5] || (code_c == 6'h1f);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_req_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_req_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend) |-> (req_cnt == 3'(nw_c) + 3'(mem_c)));

  assert_no_lit_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend && lit_c) |-> (dst_kind_o == 3'd0));

  assert_cost_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend) |-> (cycles_o == CYC_W'(nw_c)));

  assert_pc_adv_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend) |-> (pc_o == (nw_c ? pc_c + DW'(1) : pc_c)));

  assert_pop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend && code_c == 6'h18) |-> (sp_o == sp_c + DW'(1) && dst_addr_o == sp_c));

  assert_push_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pend && code_c == 6'h1a) |-> (sp_o == sp_c - DW'(1) && dst_addr_o == sp_o));
endmodule

bind opr_resolver opr_resolver_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .code_i     (code_i),
  .sp_i       (sp_i),
  .pc_i       (pc_i),
  .mem_req_o  (mem_req_o),
  .done_o     (done_o),
  .dst_kind_o (dst_kind_o),
  .dst_addr_o (dst_addr_o),
  .sp_o       (sp_o),
  .pc_o       (pc_o),
  .cycles_o   (cycles_o)
);

// File: tb/tb_opr_resolver.sv
module tb_opr_resolver;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [5:0]   code_i = '0;
  logic [127:0] regs_i = '0;
  logic [15:0]  sp_i = '0, pc_i = '0, o_i = '0;
  logic         mem_req_o;
  logic [15:0]  mem_addr_o;
  logic [15:0]  mem_rdata_i = '0;
  logic         done_o;
  logic [15:0]  value_o;
  logic [2:0]   dst_kind_o;
  logic [2:0]   dst_sel_o;
  logic [15:0]  dst_addr_o, sp_o, pc_o;
  logic [1:0]   cycles_o;

  int checks = 0;
  int errors = 0;

  opr_resolver dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .code_i(code_i),
    .regs_i(regs_i), .sp_i(sp_i), .pc_i(pc_i), .o_i(o_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .value_o(value_o), .dst_kind_o(dst_kind_o),
    .dst_sel_o(dst_sel_o), .dst_addr_o(dst_addr_o), .sp_o(sp_o),
    .pc_o(pc_o), .cycles_o(cycles_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] memf(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'hc3a5;
  endfunction

  // synchronous read memory, one cycle latency
  always @(posedge clk) if (mem_req_o) mem_rdata_i <= memf(mem_addr_o);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(logic [5:0] code, logic [127:0] regs, logic [15:0] sp,
                        logic [15:0] pc, logic [15:0] ov, bit inj);
    logic [15:0] r, nw, val, addr, esp, epc, maddr;
    logic [2:0]  kind;
    bit          need_nw, need_mem;
    int          lat;
    string       tag;
    r        = regs[code[2:0]*16 +: 16];
    nw       = memf(pc);
    need_nw  = (code[5:3] == 3'd2) || code == 6'h1e || code == 6'h1f;
    esp      = sp;
    epc      = need_nw ? pc + 16'd1 : pc;
    addr     = 16'h0;
    maddr    = 16'h0;
    need_mem = 1'b0;
    kind     = 3'd0;
    val      = 16'h0;
    if (code < 6'h08)      begin tag = "R1"; val = r; kind = 3'd1; end
    else if (code < 6'h10) begin tag = "R2"; maddr = r; need_mem = 1; end
    else if (code < 6'h18) begin tag = "R3"; maddr = nw + r; need_mem = 1; end
    else if (code == 6'h18) begin tag = "R4"; maddr = sp; esp = sp + 16'd1; need_mem = 1; end
    else if (code == 6'h19) begin tag = "R4"; maddr = sp; need_mem = 1; end
    else if (code == 6'h1a) begin tag = "R5"; esp = sp - 16'd1; maddr = esp; need_mem = 1; end
    else if (code == 6'h1b) begin tag = "R6"; val = sp; kind = 3'd3; end
    else if (code == 6'h1c) begin tag = "R6"; val = pc; kind = 3'd4; end
    else if (code == 6'h1d) begin tag = "R6"; val = ov; kind = 3'd5; end
    else if (code == 6'h1e) begin tag = "R7"; maddr = nw; need_mem = 1; end
    else if (code == 6'h1f) begin tag = "R7"; val = nw; end
    else                    begin tag = "R7"; val = {10'd0, code - 6'h20}; end
    if (need_mem) begin val = memf(maddr); kind = 3'd2; addr = maddr; end
    lat = 1 + (need_nw ? 2 : 0) + (need_mem ? 2 : 0);

    @(negedge clk);
    code_i = code; regs_i = regs; sp_i = sp; pc_i = pc; o_i = ov; start_i = 1'b1;
    for (int k = 1; k <= lat + 1; k++) begin
      bit exp_req;
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (inj && k == 2) begin start_i = 1'b1; code_i = 6'h20; sp_i = ~sp; pc_i = ~pc; end
      if (inj && k == 3) start_i = 1'b0;
      exp_req = (k == 1 && (need_nw || need_mem)) || (k == 3 && need_nw && need_mem);
      chk("R11", "done_o", 32'(done_o), 32'(k == lat));
      chk("R10", "mem_req_o", 32'(mem_req_o), 32'(exp_req));
      if (exp_req)
        chk("R10", "mem_addr_o", 32'(mem_addr_o), 32'((k == 1 && need_nw) ? pc : maddr));
      if (k == lat) begin
        chk(tag, "value_o", 32'(value_o), 32'(val));
        chk((kind == 3'd0 && code >= 6'h1f) ? "R8" : tag, "dst_kind_o", 32'(dst_kind_o), 32'(kind));
        if (kind == 3'd1) chk("R1", "dst_sel_o", 32'(dst_sel_o), 32'(code[2:0]));
        chk(kind == 3'd2 ? tag : "R8", "dst_addr_o", 32'(dst_addr_o), 32'(addr));
        chk(tag, "sp_o", 32'(sp_o), 32'(esp));
        chk("R9", "pc_o", 32'(pc_o), 32'(epc));
        chk("R9", "cycles_o", 32'(cycles_o), 32'(need_nw));
      end
    end
  endtask

  function automatic logic [127:0] mkregs(int seed);
    logic [127:0] v;
    for (int i = 0; i < 8; i++) v[i*16 +: 16] = 16'(seed * 16'h1357 + i * 16'h2a1b + 16'h0100);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "done_o in reset", 32'(done_o), 32'd0);
    chk("R12", "mem_req_o in reset", 32'(mem_req_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    // every code, two data sets
    for (int c = 0; c < 64; c++)
      run_op(6'(c), mkregs(c), 16'(16'h8000 + c * 7), 16'(16'h0400 + c * 3), 16'hbeef, 1'b0);
    for (int c = 63; c >= 0; c--)
      run_op(6'(c), mkregs(c + 91), 16'(c * 16'h0123), 16'(16'hf000 - c * 5), 16'h0001, 1'b0);
    // R5: push from SP 0 wraps to top of memory
    run_op(6'h1a, mkregs(3), 16'h0000, 16'h0010, 16'h0, 1'b0);
    // R4: pop at 0xffff wraps SP to 0; peek leaves SP
    run_op(6'h18, mkregs(4), 16'hffff, 16'h0010, 16'h0, 1'b0);
    run_op(6'h19, mkregs(4), 16'h0000, 16'h0010, 16'h0, 1'b0);
    // R3: index sum wraps; PC at 0xffff wraps after fetch (R9)
    run_op(6'h17, {16'hfff0, 112'h0}, 16'h0, 16'h1234, 16'h0, 1'b0);
    run_op(6'h1f, mkregs(5), 16'h0, 16'hffff, 16'h0, 1'b0);
    run_op(6'h12, mkregs(6), 16'h0, 16'hffff, 16'h0, 1'b0);
    // R11: start while busy is ignored
    run_op(6'h13, mkregs(7), 16'h4000, 16'h0200, 16'h0, 1'b1);
    run_op(6'h0a, mkregs(8), 16'h4000, 16'h0200, 16'h0, 1'b1);
    run_op(6'h3f, mkregs(9), 16'h0, 16'h0, 16'h0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule